// File: doc/BRIEF.md
# Audio Master-Clock Ratio Detector

This block runs on a fast master clock and watches a frame (left/right) clock that is already synchronous to it. It counts the master-clock cycles in each frame period, matches the count against the supported oversampling ratios, and reports the ratio together with a sampling-speed mode: normal, double or quad. A new result is only taken after two frames in a row agree.

The speed comes from one of two places. In manual mode a two-bit select names it, and the measured ratio must belong to that speed. In automatic mode the speed follows from the measured ratio. A separate parallel-pin control mode ignores the configured select and uses a single pin to choose between manual normal speed and automatic mode.

The block holds the downstream datapath in power-down until frame edges arrive, and again whenever they stop. A confirmed ratio that the current mode does not permit raises a sticky flag and leaves the last good speed and ratio in place.

Top module: `mclk_ratio_detect`

## Requirements
- R1: After reset, `pwrdn_o`=1, `speed_o`=00, `ratio_o`=7, `ratio_ok_o`=0 and `invalid_o`=0. The configured mode is automatic with select 00.
- R2: `pwrdn_o` falls once a rising frame-clock edge has been seen. It rises again if no rising edge arrives within `TIMEOUT` (2048) master-clock cycles. After a loss, the first edge only re-arms the measurement.
- R3: The period is counted between rising frame edges. A count within ±`TOL` (2) of a nominal value gives a ratio code: 128→0, 192→1, 256→2, 384→3, 512→4, 768→5, 1152→6. Any other count gives code 7.
- R4: The outputs change only when two consecutive measurements give the same code.
- R5: In automatic mode, codes 4–6 give speed 00 (normal), codes 2–3 give 01 (double) and codes 0–1 give 10 (quad).
- R6: In manual mode with select 00 (normal), codes 2–6 are accepted and the speed is 00.
- R7: In manual mode, select 01 (double) accepts codes 0–3 and select 10 (quad) accepts codes 0–1. The speed then equals the select. Select 11 accepts nothing.
- R8: When `par_mode_i`=1, the configured select is ignored and treated as 00. `auto_pin_i`=0 means manual normal and `auto_pin_i`=1 means automatic. Codes 0 and 1 are rejected in both cases.
- R9: A confirmed code that the current mode does not accept, code 7 included, sets `invalid_o`. The flag stays set until reset, and `speed_o`, `ratio_o` and `ratio_ok_o` keep their values.
- R10: `speed_o` and `ratio_o` only change in the cycle after a rising frame edge.
- R11: `speed_o` never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lrck_i | input | 1 | Frame clock, synchronous to `clk` |
| par_mode_i | input | 1 | Parallel-pin control mode |
| auto_pin_i | input | 1 | Auto-select pin, used in parallel-pin mode |
| cfg_we_i | input | 1 | Write strobe for the mode configuration |
| cfg_auto_i | input | 1 | Configured auto-select value |
| cfg_spd_i | input | 2 | Configured speed select |
| pwrdn_o | output | 1 | Power-down request for the datapath |
| speed_o | output | 2 | Speed: 00 normal, 01 double, 10 quad |
| ratio_o | output | 3 | Confirmed ratio code (R3) |
| ratio_ok_o | output | 1 | A ratio has been confirmed |
| invalid_o | output | 1 | Sticky flag for a rejected ratio |

## Verification
The hardest case to reach is a mode change while the frame rate stays the same. In that case the first edge of the next frame confirms the old ratio against the new mode, and this can set the sticky flag before any new ratio has been seen. The stimulus produces it by writing the configuration, or flipping the parallel pins, between frame bursts. The bench model replays the previous burst's code under the new mode before the new burst's code. Directed bursts cover a single-frame change, the tolerance edge at ±2 versus ±3, the reserved select, and a gap longer than the timeout. A seeded random series of ratios, modes and ±1 jitter follows.

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect #(
  parameter int TIMEOUT = 2048,
  parameter int TOL     = 2,
  localparam int CW     = $clog2(TIMEOUT) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrck_i,
  input  logic       par_mode_i,
  input  logic       auto_pin_i,
  input  logic       cfg_we_i,
  input  logic       cfg_auto_i,
  input  logic [1:0] cfg_spd_i,
  output logic       pwrdn_o,
  output logic [1:0] speed_o,
  output logic [2:0] ratio_o,
  output logic       ratio_ok_o,
  output logic       invalid_o
);

  localparam logic [2:0] NONE = 3'd7;

  function automatic int nominal(input int i);
    case (i)
      0: return 128;
      1: return 192;
      2: return 256;
      3: return 384;
      4: return 512;
      5: return 768;
      default: return 1152;
    endcase
  endfunction

  logic          lrck_q, clk_ok, armed, last_vld;
  logic          cfg_auto;
  logic [1:0]    cfg_spd;
  logic [CW-1:0] cnt, meas;
  logic [2:0]    code, last_code;
  logic          eff_auto, accept;
  logic [1:0]    eff_spd, tgt_speed;
  logic          rise;

  assign rise     = lrck_i & ~lrck_q;
  assign meas     = cnt + 1'b1;
  assign eff_auto = par_mode_i ? auto_pin_i : cfg_auto;
  assign eff_spd  = par_mode_i ? 2'b00 : cfg_spd;
  assign pwrdn_o  = ~clk_ok;

  always_comb begin
    code = NONE;
    for (int i = 0; i < 7; i++)
      if (int'(meas) >= nominal(i) - TOL && int'(meas) <= nominal(i) + TOL)
        code = 3'(i);
  end

  always_comb begin
    accept    = 1'b0;
    tgt_speed = eff_spd;
    if (code != NONE) begin
      if (eff_auto) begin
        accept    = !(par_mode_i && code <= 3'd1);
        tgt_speed = (code <= 3'd1) ? 2'b10 : (code <= 3'd3) ? 2'b01 : 2'b00;
      end else begin
        case (eff_spd)
          2'b00:   accept = (code >= 3'd2);
          2'b01:   accept = (code <= 3'd3);
          2'b10:   accept = (code <= 3'd1);
          default: accept = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_auto <= 1'b1;
      cfg_spd  <= 2'b00;
    end else if (cfg_we_i) begin
      cfg_auto <= cfg_auto_i;
      cfg_spd  <= cfg_spd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q     <= 1'b0;
      cnt        <= '0;
      clk_ok     <= 1'b0;
      armed      <= 1'b0;
      last_vld   <= 1'b0;
      last_code  <= NONE;
      speed_o    <= 2'b00;
      ratio_o    <= NONE;
      ratio_ok_o <= 1'b0;
      invalid_o  <= 1'b0;
    end else begin
      lrck_q <= lrck_i;
      if (rise) begin
        cnt    <= '0;
        clk_ok <= 1'b1;
        armed  <= 1'b1;
        if (armed) begin
          last_code <= code;
          last_vld  <= 1'b1;
          if (last_vld && code == last_code) begin
            if (accept) begin
              speed_o    <= tgt_speed;
              ratio_o    <= code;
              ratio_ok_o <= 1'b1;
            end else begin
              invalid_o  <= 1'b1;
            end
          end
        end
      end else if (int'(cnt) == TIMEOUT - 1) begin
        clk_ok   <= 1'b0;
        armed    <= 1'b0;
        last_vld <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mclk_ratio_detect_chk.sv
module mclk_ratio_detect_chk #(
  parameter int TIMEOUT = 2048
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lrck_i,
  input logic       pwrdn_o,
  input logic [1:0] speed_o,
  input logic [2:0] ratio_o,
  input logic       ratio_ok_o,
  input logic       invalid_o
);
  localparam int GW = $clog2(TIMEOUT + 2) + 1;

  logic          lrck_d;
  logic [GW-1:0] gap;
  logic          seen_rise;

  assign seen_rise = lrck_i & ~lrck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_d <= 1'b0;
      gap    <= '0;
    end else begin
      lrck_d <= lrck_i;
      if (seen_rise) gap <= '0;
      else if (int'(gap) <= TIMEOUT) gap <= gap + 1'b1;
    end
  end

  // R11
  speed_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    speed_o != 2'b11);

  // R9
  invalid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |=> invalid_o);

  // R10
  hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_rise |=> ($stable(speed_o) && $stable(ratio_o)));

  // R2
  clock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gap) > TIMEOUT) |-> pwrdn_o);

  // R2
  release_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_rise |=> !$fell(pwrdn_o));

  // R3
  ok_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_ok_o |-> (ratio_o != 3'd7));
endmodule

bind mclk_ratio_detect mclk_ratio_detect_chk #(.TIMEOUT(TIMEOUT)) u_chk (.*);

// File: tb/tb_mclk_ratio_detect.sv
module tb_mclk_ratio_detect;
  logic clk = 1'b0, rst_n = 1'b0, lrck_i = 1'b0;
  logic par_mode_i = 1'b0, auto_pin_i = 1'b0;
  logic cfg_we_i = 1'b0, cfg_auto_i = 1'b0;
  logic [1:0] cfg_spd_i = 2'b00;
  logic pwrdn_o, ratio_ok_o, invalid_o;
  logic [1:0] speed_o;
  logic [2:0] ratio_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int e_speed, e_ratio, e_ok, e_inv, e_pd;
  bit b_auto, b_par, b_pin, armed_b;
  int b_spd, prev_c;

  always #4 clk = ~clk;

  mclk_ratio_detect dut (.*);

  function automatic int nom(input int i);
    case (i)
      0: return 128; 1: return 192; 2: return 256; 3: return 384;
      4: return 512; 5: return 768; default: return 1152;
    endcase
  endfunction

  function automatic int f_code(input int p);
    for (int i = 0; i < 7; i++)
      if (p >= nom(i) - 2 && p <= nom(i) + 2) return i;
    return 7;
  endfunction

  function automatic bit f_ok(input int c);
    bit au = b_par ? b_pin : b_auto;
    int sp = b_par ? 0 : b_spd;
    if (c == 7) return 0;
    if (au) return !(b_par && c <= 1);
    case (sp)
      0: return c >= 2;
      1: return c <= 3;
      2: return c <= 1;
      default: return 0;
    endcase
  endfunction

  function automatic int f_speed(input int c);
    bit au = b_par ? b_pin : b_auto;
    if (au) return (c <= 1) ? 2 : (c <= 3) ? 1 : 0;
    return b_par ? 0 : b_spd;
  endfunction

  function automatic void apply(input int c);
    if (f_ok(c)) begin e_speed = f_speed(c); e_ratio = c; e_ok = 1; end
    else e_inv = 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " speed"}, int'(speed_o), e_speed);
    chk({tag, " ratio"}, int'(ratio_o), e_ratio);
    chk({tag, " ok"}, int'(ratio_ok_o), e_ok);
    chk({tag, " invalid"}, int'(invalid_o), e_inv);
    chk({tag, " pwrdn"}, int'(pwrdn_o), e_pd);
  endtask

  task automatic do_reset();
    lrck_i = 0; cfg_we_i = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    e_speed = 0; e_ratio = 7; e_ok = 0; e_inv = 0; e_pd = 1;
    b_auto = 1; b_spd = 0; armed_b = 0; prev_c = 7;
  endtask

  task automatic cfg_wr(input bit a, input int s);
    cfg_auto_i = a; cfg_spd_i = 2'(s); cfg_we_i = 1;
    b_auto = a; b_spd = s;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic seg(input int p, input int n, input int jit);
    int c = f_code(p);
    if (armed_b) apply(prev_c);
    for (int k = 0; k < n; k++) begin
      int q = p + ((jit > 0) ? (int'($urandom % (2 * jit + 1)) - jit) : 0);
      lrck_i = 1; repeat (q / 2) @(negedge clk);
      lrck_i = 0; repeat (q - q / 2) @(negedge clk);
    end
    if (n >= 3) apply(c);
    prev_c = c; armed_b = 1; e_pd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    chk_all("R1 reset");

    seg(256, 2, 0);
    chk_all("R4 R10 single match, R2 release");
    seg(256, 3, 0);
    chk_all("R5 auto 256 double");
    seg(1152, 4, 0);
    chk_all("R5 auto 1152 normal");
    seg(128, 4, 0);
    chk_all("R5 R11 auto 128 quad");

    cfg_wr(0, 0);
    seg(512, 4, 0);
    chk_all("R6 manual normal 512");
    seg(384, 4, 0);
    chk_all("R6 manual normal 384");
    cfg_wr(0, 1);
    seg(192, 4, 0);
    chk_all("R7 manual double 192");
    cfg_wr(0, 2);
    seg(128, 4, 0);
    chk_all("R7 manual quad 128");

    b_par = 1; b_pin = 1; par_mode_i = 1; auto_pin_i = 1;
    seg(384, 4, 0);
    chk_all("R8 pin auto 384");
    b_pin = 0; auto_pin_i = 0;
    seg(768, 4, 0);
    chk_all("R8 pin manual 768");
    seg(192, 4, 0);
    chk_all("R8 R9 pin rejects 192");
    b_par = 0; par_mode_i = 0;

    do_reset();
    chk_all("R1 R9 reset clears flag");
    seg(258, 4, 0);
    chk_all("R3 tolerance +2");
    seg(253, 4, 0);
    chk_all("R3 tolerance -3 rejected, R9 held");

    do_reset();
    cfg_wr(0, 3);
    seg(256, 4, 0);
    chk_all("R7 reserved select");

    do_reset();
    seg(512, 4, 0);
    lrck_i = 0;
    repeat (2100) @(negedge clk);
    e_pd = 1; armed_b = 0;
    chk_all("R2 clock loss");
    seg(768, 3, 0);
    chk_all("R2 re-arm after loss");

    do_reset();
    for (int i = 0; i < 16; i++) begin
      int idx = int'($urandom % 8);
      int p = (idx == 7) ? 640 : nom(idx);
      b_par = ($urandom % 4) == 0; par_mode_i = b_par;
      b_pin = $urandom % 2; auto_pin_i = b_pin;
      cfg_wr(1'($urandom % 2), ($urandom % 5 == 0) ? 3 : int'($urandom % 3));
      seg(p, 4, 1);
      chk_all("R3 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule